// File: doc/BRIEF.md
# Register Renamer with Undo History

This block sits in the rename stage of an out-of-order pipeline and handles at most one instruction per cycle. It reads two architectural source operands and returns the physical register each one is currently bound to, together with that register's ready bit. For a destination operand it takes a fresh physical register from a free pool and marks that register not ready. It returns both the new and the displaced physical register, and it logs the change in a history ring so the change can be taken back later.

Architectural indices below the floating-point boundary (`ARCH_INT`) are integer registers. They are shifted through a register window before any table access. Indices at or above the boundary pass through unchanged. A squash rolls back, from youngest to oldest and one entry per cycle, every logged rename whose sequence number is larger than the squash point. A commit retires the oldest logged entry when its sequence number is at or below the commit point, and the displaced register is released. A wakeup port sets a scoreboard bit for a register whose result is available.

Top module: `reg_renamer`

## Requirements
- R1: After reset, architectural register a maps to physical register a, every physical register reads ready, the history is empty and `ren_ready` is high.
- R2: A source or destination index a below `ARCH_INT` is used as (a + `win_base`) mod `ARCH_INT`. An index at or above `ARCH_INT` (floating point) is used unchanged.
- R3: `srcN_phys` shows the current mapping of the flattened source index in the same cycle, combinationally.
- R4: When `dst_valid` is high, `dst_prev` shows the current mapping of the flattened destination and `dst_phys` shows the register to be allocated. On acceptance the map holds `dst_phys` from the next cycle, and `dst_phys` differs from `dst_prev`.
- R5: `srcN_rdy` shows the ready bit of `srcN_phys`. An accepted destination register reads not ready from the next cycle. A `wake_valid` pulse sets the ready bit of `wake_phys` from the next cycle, and an allocation of the same register in the same cycle wins.
- R6: Every accepted destination rename adds one history entry. With `dst_valid` high, `ren_ready` is low when the history holds `HIST_DEPTH` entries or no physical register is free. An instruction without a destination is not held back by either condition.
- R7: In the cycle `squash_valid` is high, and while rollback runs, `ren_ready` is low. Rollback undoes one entry per cycle, youngest first, for each entry whose sequence number is greater than `squash_seq`. Each undo restores the previous mapping and frees the new register.
- R8: In a cycle with `commit_valid` high and no squash or rollback active, the oldest entry is removed when its sequence number is at or below `commit_seq`, and its previous register becomes free from the next cycle. A commit during a squash or rollback is ignored.
- R9: Sources are read before the same instruction's destination rename takes effect, so a source equal to the destination returns the displaced register.
- R10: The allocated register is the lowest-numbered free physical register. A register freed by commit or rollback can be allocated from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ren_valid | input | 1 | An instruction is offered for rename |
| ren_ready | output | 1 | Rename accepts the offered instruction this cycle |
| ren_seq | input | SEQ_W | Sequence number of the offered instruction |
| win_base | input | $clog2(ARCH_INT) | Integer register window offset |
| src0_arch | input | $clog2(ARCH) | First source architectural index |
| src1_arch | input | $clog2(ARCH) | Second source architectural index |
| dst_valid | input | 1 | Instruction has a destination |
| dst_arch | input | $clog2(ARCH) | Destination architectural index |
| src0_phys | output | $clog2(PHYS) | First source physical register |
| src0_rdy | output | 1 | First source ready bit |
| src1_phys | output | $clog2(PHYS) | Second source physical register |
| src1_rdy | output | 1 | Second source ready bit |
| dst_phys | output | $clog2(PHYS) | Newly allocated destination register |
| dst_prev | output | $clog2(PHYS) | Register previously mapped to the destination |
| squash_valid | input | 1 | Start a rollback |
| squash_seq | input | SEQ_W | Youngest sequence number that survives the squash |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Oldest-retire limit |
| wake_valid | input | 1 | Set a scoreboard bit |
| wake_phys | input | $clog2(PHYS) | Register to mark ready |

## Verification
Lookup results (`srcN_phys`, `srcN_rdy`, `dst_phys`, `dst_prev`) and `ren_ready` are combinational, so they are due in the same cycle as the input they answer. Every state change (map update, ready clear, wakeup, commit free, undo step) shows up one cycle after the edge that takes it. Rollback ends with one further cycle that finds no qualifying entry. Inputs are changed shortly after each rising edge and outputs are sampled 15 ns after it. A behavioural model updated on the same edge predicts every output, and the outputs are compared on every cycle. A directed opening then pins down the reset map, window flattening, source-equals-destination, lowest-first allocation, commit reuse and rollback.

// File: rtl/reg_renamer.sv
module reg_renamer #(
  parameter int ARCH_INT   = 8,
  parameter int ARCH_FP    = 8,
  parameter int PHYS_INT   = 12,
  parameter int PHYS_FP    = 12,
  parameter int HIST_DEPTH = 8,
  parameter int SEQ_W      = 16,
  localparam int ARCH = ARCH_INT + ARCH_FP,
  localparam int PHYS = PHYS_INT + PHYS_FP,
  localparam int AW   = $clog2(ARCH),
  localparam int PW   = $clog2(PHYS),
  localparam int IW   = $clog2(ARCH_INT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ren_valid,
  output logic             ren_ready,
  input  logic [SEQ_W-1:0] ren_seq,
  input  logic [IW-1:0]    win_base,
  input  logic [AW-1:0]    src0_arch,
  input  logic [AW-1:0]    src1_arch,
  input  logic             dst_valid,
  input  logic [AW-1:0]    dst_arch,
  output logic [PW-1:0]    src0_phys,
  output logic             src0_rdy,
  output logic [PW-1:0]    src1_phys,
  output logic             src1_rdy,
  output logic [PW-1:0]    dst_phys,
  output logic [PW-1:0]    dst_prev,
  input  logic             squash_valid,
  input  logic [SEQ_W-1:0] squash_seq,
  input  logic             commit_valid,
  input  logic [SEQ_W-1:0] commit_seq,
  input  logic             wake_valid,
  input  logic [PW-1:0]    wake_phys
);
  localparam int HW = $clog2(HIST_DEPTH);
  localparam int CW = $clog2(HIST_DEPTH + 1);

  function automatic logic [AW-1:0] flatten(input logic [AW-1:0] a, input logic [IW-1:0] wb);
    logic [IW-1:0] s;
    s = a[IW-1:0] + wb;
    if (int'(a) < ARCH_INT) return {{(AW-IW){1'b0}}, s};
    return a;
  endfunction

  logic [PW-1:0]    map_q  [ARCH];
  logic [PHYS-1:0]  free_q;
  logic [PHYS-1:0]  rdy_q;
  logic [SEQ_W-1:0] h_seq  [HIST_DEPTH];
  logic [AW-1:0]    h_arch [HIST_DEPTH];
  logic [PW-1:0]    h_new  [HIST_DEPTH];
  logic [PW-1:0]    h_prev [HIST_DEPTH];
  logic [HW-1:0]    head_q;
  logic [CW-1:0]    cnt_q;
  logic             undo_q;
  logic [SEQ_W-1:0] sq_seq_q;

  logic [AW-1:0] s0f, s1f, df;
  logic [PW-1:0] alloc;
  logic [HW-1:0] young, tail;
  logic          acc, push, pop, undo_now, hist_full;

  assign s0f = flatten(src0_arch, win_base);
  assign s1f = flatten(src1_arch, win_base);
  assign df  = flatten(dst_arch, win_base);

  assign src0_phys = map_q[s0f];
  assign src1_phys = map_q[s1f];
  assign src0_rdy  = rdy_q[src0_phys];
  assign src1_rdy  = rdy_q[src1_phys];
  assign dst_prev  = map_q[df];
  assign dst_phys  = alloc;

  always_comb begin
    alloc = '0;
    for (int i = PHYS - 1; i >= 0; i--)
      if (free_q[i]) alloc = PW'(i);
  end

  assign hist_full = (int'(cnt_q) == HIST_DEPTH);
  assign ren_ready = !undo_q && !squash_valid && (!dst_valid || (|free_q && !hist_full));
  assign acc  = ren_valid && ren_ready;
  assign push = acc && dst_valid;

  assign young = head_q + cnt_q[HW-1:0] - HW'(1);
  assign tail  = head_q + cnt_q[HW-1:0];

  assign undo_now = undo_q && cnt_q != '0 && h_seq[young] > sq_seq_q;
  assign pop = commit_valid && !undo_q && !squash_valid && cnt_q != '0 &&
               h_seq[head_q] <= commit_seq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH; i++) map_q[i] <= PW'(i);
      for (int i = 0; i < PHYS; i++) free_q[i] <= (i >= ARCH);
      rdy_q    <= '1;
      head_q   <= '0;
      cnt_q    <= '0;
      undo_q   <= 1'b0;
      sq_seq_q <= '0;
    end else begin
      if (undo_now) begin
        map_q[h_arch[young]] <= h_prev[young];
        free_q[h_new[young]] <= 1'b1;
      end
      if (undo_q && !undo_now) undo_q <= 1'b0;
      if (pop) free_q[h_prev[head_q]] <= 1'b1;
      if (push) begin
        map_q[df]     <= alloc;
        free_q[alloc] <= 1'b0;
        h_seq[tail]   <= ren_seq;
        h_arch[tail]  <= df;
        h_new[tail]   <= alloc;
        h_prev[tail]  <= map_q[df];
      end
      if (wake_valid && int'(wake_phys) < PHYS) rdy_q[wake_phys] <= 1'b1;
      if (push) rdy_q[alloc] <= 1'b0;
      head_q <= head_q + HW'(pop);
      cnt_q  <= cnt_q + CW'(push) - CW'(pop) - CW'(undo_now);
      if (squash_valid) begin
        undo_q   <= 1'b1;
        sq_seq_q <= squash_seq;
      end
    end
  end
endmodule

// File: rtl/reg_renamer_chk.sv
module reg_renamer_chk #(
  parameter int ARCH  = 16,
  parameter int PHYS  = 24,
  parameter int DEPTH = 8,
  parameter int PW    = 5,
  parameter int CW    = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ren_valid,
  input logic            ren_ready,
  input logic            dst_valid,
  input logic            squash_valid,
  input logic [PW-1:0]   dst_phys,
  input logic [PW-1:0]   dst_prev,
  input logic [PHYS-1:0] free_vec,
  input logic [PHYS-1:0] rdy_vec,
  input logic [CW-1:0]   cnt
);
  assert_prev_differs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ren_valid && ren_ready && dst_valid |-> dst_phys != dst_prev);

  assert_alloc_from_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ren_valid && ren_ready && dst_valid |-> free_vec[dst_phys]);

  assert_new_not_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ren_valid && ren_ready && dst_valid |=> !rdy_vec[$past(dst_phys)]);

  assert_squash_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |-> !ren_ready);

  assert_hist_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= DEPTH);

  assert_full_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) == DEPTH && dst_valid |-> !ren_ready);

  assert_pool_balance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(free_vec) + int'(cnt) == PHYS - ARCH);
endmodule

bind reg_renamer reg_renamer_chk #(
  .ARCH(ARCH), .PHYS(PHYS), .DEPTH(HIST_DEPTH), .PW(PW), .CW(CW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_ready(ren_ready),
  .dst_valid(dst_valid), .squash_valid(squash_valid), .dst_phys(dst_phys),
  .dst_prev(dst_prev), .free_vec(free_q), .rdy_vec(rdy_q), .cnt(cnt_q)
);

// File: tb/reg_renamer_tb_top.sv
module reg_renamer_tb_top;
  localparam int NA = 16, NI = 8, NP = 24, DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ren_valid = 0, dst_valid = 0, squash_valid = 0, commit_valid = 0, wake_valid = 0;
  logic [15:0] ren_seq = 0, squash_seq = 0, commit_seq = 0;
  logic [2:0]  win_base = 0;
  logic [3:0]  src0_arch = 0, src1_arch = 0, dst_arch = 0;
  logic [4:0]  wake_phys = 0;
  logic        ren_ready, src0_rdy, src1_rdy;
  logic [4:0]  src0_phys, src1_phys, dst_phys, dst_prev;

  always #10 clk = ~clk;

  reg_renamer dut_i (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_ready(ren_ready),
    .ren_seq(ren_seq), .win_base(win_base), .src0_arch(src0_arch),
    .src1_arch(src1_arch), .dst_valid(dst_valid), .dst_arch(dst_arch),
    .src0_phys(src0_phys), .src0_rdy(src0_rdy), .src1_phys(src1_phys),
    .src1_rdy(src1_rdy), .dst_phys(dst_phys), .dst_prev(dst_prev),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .wake_valid(wake_valid), .wake_phys(wake_phys)
  );

  int checks = 0, fails = 0;

  typedef struct { int seq; int arch; int nw; int prev; } hent_t;
  int    m_map [NA];
  bit    m_free[NP];
  bit    m_rdy [NP];
  hent_t hq[$];
  bit    m_undo;
  int    m_sq;
  bit    m_accept;

  function automatic int flat(int a, int wb);
    return (a < NI) ? (a + wb) % NI : a;
  endfunction

  function automatic int low_free();
    for (int i = 0; i < NP; i++) if (m_free[i]) return i;
    return -1;
  endfunction

  function automatic bit exp_ready();
    return !m_undo && !squash_valid &&
           (!dst_valid || (low_free() >= 0 && hq.size() < DEPTH));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NA; i++) m_map[i] = i;
      for (int i = 0; i < NP; i++) begin m_free[i] = (i >= NA); m_rdy[i] = 1; end
      hq.delete();
      m_undo = 0; m_sq = 0; m_accept = 0;
    end else begin
      automatic int  a    = low_free();
      automatic int  fd   = flat(dst_arch, win_base);
      automatic int  pv   = m_map[fd];
      automatic bit  acc  = ren_valid && exp_ready();
      automatic bit  push = acc && dst_valid;
      hent_t e;
      m_accept = acc;
      if (m_undo) begin
        if (hq.size() > 0 && hq[$].seq > m_sq) begin
          e = hq.pop_back();
          m_map[e.arch] = e.prev;
          m_free[e.nw] = 1;
        end else m_undo = 0;
      end else if (commit_valid && !squash_valid && hq.size() > 0 && hq[0].seq <= int'(commit_seq)) begin
        e = hq.pop_front();
        m_free[e.prev] = 1;
      end
      if (push) begin
        m_map[fd] = a;
        m_free[a] = 0;
        hq.push_back('{seq: int'(ren_seq), arch: fd, nw: a, prev: pv});
      end
      if (wake_valid && wake_phys < NP) m_rdy[wake_phys] = 1;
      if (push) m_rdy[a] = 0;
      if (squash_valid) begin m_undo = 1; m_sq = int'(squash_seq); end
    end
  end

  always @(posedge clk) begin
    #15;
    if (rst_n) begin
      automatic int p0 = m_map[flat(src0_arch, win_base)];
      automatic int p1 = m_map[flat(src1_arch, win_base)];
      check("R6 R7 ren_ready", ren_ready, exp_ready());
      check("R2 R3 src0_phys", src0_phys, p0);
      check("R2 R3 src1_phys", src1_phys, p1);
      check("R5 src0_rdy", src0_rdy, m_rdy[p0]);
      check("R5 src1_rdy", src1_rdy, m_rdy[p1]);
      check("R4 R9 dst_prev", dst_prev, m_map[flat(dst_arch, win_base)]);
      if (low_free() >= 0) check("R10 R8 dst_phys", dst_phys, low_free());
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  int next_seq = 1;

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    src0_arch = 5; src1_arch = 12;
    #13;
    check("R1 reset map", src0_phys, 5);
    check("R1 reset ready", src0_rdy, 1);
    check("R1 fp map", src1_phys, 12);
    check("R1 ren_ready", ren_ready, 1);

    step();
    ren_valid = 1; ren_seq = 1; src0_arch = 1; dst_valid = 1; dst_arch = 1;
    #13;
    check("R9 src equals dst", src0_phys, 1);
    check("R10 first alloc", dst_phys, 16);
    check("R4 prev", dst_prev, 1);

    step();
    ren_seq = 2; src0_arch = 1; dst_arch = 9;
    #13;
    check("R4 map updated", src0_phys, 16);
    check("R5 new not ready", src0_rdy, 0);
    check("R10 next alloc", dst_phys, 17);

    step();
    ren_valid = 0; dst_valid = 0; win_base = 3; src0_arch = 6; src1_arch = 9;
    wake_valid = 1; wake_phys = 16;
    #13;
    check("R2 int flattened", src0_phys, 16);
    check("R2 fp unflattened", src1_phys, 17);

    step();
    wake_valid = 0;
    #13;
    check("R5 wake sets ready", src0_rdy, 1);

    step();
    commit_valid = 1; commit_seq = 1;
    step();
    commit_valid = 0; dst_valid = 1; dst_arch = 12;
    #13;
    check("R8 commit frees prev", dst_phys, 1);

    step();
    dst_valid = 0; squash_valid = 1; squash_seq = 1;
    #13;
    check("R7 squash stalls", ren_ready, 0);
    step();
    squash_valid = 0; win_base = 0; src0_arch = 9;
    step();
    step();
    #13;
    check("R7 rollback restores", src0_phys, 9);
    check("R7 rollback done", ren_ready, 1);
    next_seq = 2;

    for (int c = 0; c < 3000; c++) begin
      step();
      if (m_accept) next_seq++;
      if (squash_valid) next_seq = int'(squash_seq) + 1;
      ren_valid = ($urandom % 4) != 0;
      dst_valid = ($urandom % 4) != 0;
      ren_seq   = 16'(next_seq);
      src0_arch = 4'($urandom); src1_arch = 4'($urandom); dst_arch = 4'($urandom);
      if ($urandom % 16 == 0) win_base = 3'($urandom);
      wake_valid = ($urandom % 3) == 0;
      wake_phys  = 5'($urandom % NP);
      commit_valid = ($urandom % 3) == 0;
      commit_seq   = 16'((next_seq > 6) ? next_seq - 1 - int'($urandom % 6) : 0);
      squash_valid = ($urandom % 25) == 0;
      squash_seq   = 16'((next_seq > 4) ? next_seq - 1 - int'($urandom % 4) : 0);
    end
    step();
    ren_valid = 0; dst_valid = 0; wake_valid = 0; commit_valid = 0; squash_valid = 0;
    repeat (4) step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule